// File: doc/BRIEF.md
# 32-bit to 64-bit Register Bridge

This block sits on a 32-bit register bus as a slave and gives the host access to a 64-bit register space on an inner bus. The host cannot move 64 bits at once, so it places each half of a value in its own 32-bit staging register. It then writes a command word. The command word carries a direction bit and an inner address, and writing it launches exactly one 64-bit access on the inner bus.

For a write, the two staged halves go out together with the address. For a read, the returned 64-bit value is captured into the same two staging registers, where the host picks it up with two outer reads. The inner bus uses a request/acknowledge handshake. Each access has a cycle limit; an access that runs past it is dropped.

Errors are kept in sticky status bits. These cover a timeout, a command written while an access is still in flight, and an address that leaves the inner range once the fixed base offset is added. A summary bit collects all of them. The host checks that bit after each command and clears the errors by writing the reset register. An interrupt register lets the summary bit drive an interrupt line.

Top module: `bridge32to64`

## Requirements
- R1: After a synchronous active-low reset, every readable register reads zero, `in_req` is low and `irq` is low.
- R2: The register at byte offset 0x00 holds bits 63:32 of the inner value and the one at 0x04 holds bits 31:0. Both read back what the host last wrote, unless a read completion has replaced them.
- R3: Writing offset 0x08 with bit 31 set launches an inner write while the bridge is idle. From the next cycle, `in_req`=1 and `in_we`=1, `in_wdata` is {data 0x00, data 0x04}, and `in_addr` is command bits 30:0 plus BASE (0x70000 by default).
- R4: Writing offset 0x08 with bit 31 clear launches an inner read with `in_we`=0. The cycle in which `in_ack` is high with `in_req` captures `in_rdata[63:32]` into 0x00 and `in_rdata[31:0]` into 0x04. `in_req` is low in the following cycle.
- R5: The status register at 0x1C shows bit 0 = access in flight, bit 1 = timeout, bit 2 = command while busy, and bit 3 = address out of range. Bit 31 is the OR of bits 1 to 3. All other bits read zero.
- R6: If no acknowledge arrives within TIMEOUT (16) cycles of the request, the request is dropped and status bit 1 is set. An acknowledge in the TIMEOUT-th cycle of the request still completes normally.
- R7: A command written while an access is in flight launches nothing and sets status bit 2. The running access continues with its address unchanged.
- R8: A command is rejected when command bits 30:0 plus BASE do not fit in 31 bits. It launches nothing and sets status bit 3, whatever its direction bit.
- R9: Error bits are sticky until any write to offset 0x18. That write clears them, ends any access in flight, and causes an acknowledge that arrives later to be ignored.
- R10: Bit 0 of offset 0x20 is an interrupt enable that reads back. `irq` is high exactly when that bit and status bit 31 are both set.
- R11: Offsets 0x08, 0x18 and all unmapped offsets read zero. Writes to unmapped offsets change no register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| bus_sel | input | 1 | Outer bus access strobe |
| bus_wr | input | 1 | Outer access is a write |
| bus_addr | input | OUT_AW | Outer byte offset |
| bus_wdata | input | 32 | Outer write data |
| bus_rdata | output | 32 | Outer read data, combinational from bus_addr |
| in_req | output | 1 | Inner access request |
| in_we | output | 1 | Inner access is a write |
| in_addr | output | 31 | Inner address |
| in_wdata | output | 64 | Inner write data |
| in_ack | input | 1 | Inner acknowledge |
| in_rdata | input | 64 | Inner read data, valid with in_ack |
| irq | output | 1 | Error interrupt |

## Verification
A table drives the main function with writes and reads. The data patterns are chosen so that swapped halves, a lost upper bit, or a stale staging value each give a different readback. The addresses include zero, a mid value and the highest address that still fits after the base is added. Acknowledge delays run from the first cycle to the last cycle the limit allows, which separates a correct timeout bound from one that is off by one. Directed cases then cover the missing acknowledge, a command while busy, both directions of an out-of-range address, an abort by the reset register followed by a late acknowledge, and a write to an unmapped offset. Each of these error cases has its own expected status code.

// File: rtl/br64_pkg.sv
`timescale 1ns/1ps
// Shared constants and types of the 32-to-64 bridge.
// Assumes byte offsets fit in six bits; wider outer addresses are zero-extended.
package br64_pkg;
    localparam logic [5:0] OFS_HI  = 6'h00;
    localparam logic [5:0] OFS_LO  = 6'h04;
    localparam logic [5:0] OFS_CMD = 6'h08;
    localparam logic [5:0] OFS_RST = 6'h18;
    localparam logic [5:0] OFS_STS = 6'h1C;
    localparam logic [5:0] OFS_IRQ = 6'h20;

    localparam int STS_BUSY  = 0;
    localparam int STS_TMO   = 1;
    localparam int STS_CLASH = 2;
    localparam int STS_RANGE = 3;
    localparam int STS_ANY   = 31;

    typedef enum logic [2:0] {
        SEL_NONE, SEL_HI, SEL_LO, SEL_CMD, SEL_RST, SEL_STS, SEL_IRQ
    } regsel_e;

    typedef struct packed {
        logic hi;
        logic lo;
        logic cmd;
        logic rst;
        logic irq;
    } wstrobe_t;
endpackage

// File: rtl/br64_decode.sv
`timescale 1ns/1ps
// Outer address decode: turns the byte offset into a register select for
// reads and one write strobe per writable register.
// Assumes a single-cycle access: bus_sel is high for one cycle per access.
module br64_decode
    import br64_pkg::*;
#(
    parameter int OUT_AW = 6
) (
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OUT_AW-1:0] bus_addr,
    output regsel_e           rsel,
    output wstrobe_t          wstb
);
    localparam int NREG = 6;
    localparam logic [NREG*6-1:0] OFS_LIST =
        {OFS_IRQ, OFS_STS, OFS_RST, OFS_CMD, OFS_LO, OFS_HI};

    logic [NREG-1:0] hit;

    // one comparator per mapped offset
    for (genvar g = 0; g < NREG; g++) begin : g_cmp
        assign hit[g] = (bus_addr == OUT_AW'(OFS_LIST[g*6 +: 6]));
    end

    // read select from the comparator hits
    always_comb begin
        rsel = SEL_NONE;
        if      (hit[0]) rsel = SEL_HI;
        else if (hit[1]) rsel = SEL_LO;
        else if (hit[2]) rsel = SEL_CMD;
        else if (hit[3]) rsel = SEL_RST;
        else if (hit[4]) rsel = SEL_STS;
        else if (hit[5]) rsel = SEL_IRQ;
    end

    // write strobes qualified by a write access
    always_comb begin
        wstb.hi  = bus_sel && bus_wr && hit[0];
        wstb.lo  = bus_sel && bus_wr && hit[1];
        wstb.cmd = bus_sel && bus_wr && hit[2];
        wstb.rst = bus_sel && bus_wr && hit[3];
        wstb.irq = bus_sel && bus_wr && hit[5];
    end
endmodule

// File: rtl/br64_xfer.sv
`timescale 1ns/1ps
// Inner access engine: holds one request on the inner bus until it is
// acknowledged, times out, or is aborted.
// Assumes launch is only raised while in_req is low; the acknowledge is
// only sampled while in_req is high.
module br64_xfer #(
    parameter int IN_AW   = 31,
    parameter int WIDE_W  = 64,
    parameter int TIMEOUT = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              launch,
    input  logic              launch_we,
    input  logic [IN_AW-1:0]  launch_addr,
    input  logic [WIDE_W-1:0] launch_wdata,
    input  logic              abort,
    output logic              in_req,
    output logic              in_we,
    output logic [IN_AW-1:0]  in_addr,
    output logic [WIDE_W-1:0] in_wdata,
    input  logic              in_ack,
    output logic              rd_done,
    output logic              tmo_hit
);
    localparam int CW = (TIMEOUT > 1) ? $clog2(TIMEOUT) : 1;
    localparam logic [CW-1:0] LAST = CW'(TIMEOUT - 1);

    logic [CW-1:0] wait_cnt;
    logic          at_limit;

    assign at_limit = (wait_cnt == LAST);
    // completion and timeout events for the register side
    assign rd_done  = in_req && in_ack && !in_we && !abort;
    assign tmo_hit  = in_req && !in_ack && at_limit && !abort;

    // request, attributes and wait counter
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            in_req   <= 1'b0;
            in_we    <= 1'b0;
            in_addr  <= '0;
            in_wdata <= '0;
            wait_cnt <= '0;
        end else if (abort) begin
            in_req   <= 1'b0;
            wait_cnt <= '0;
        end else if (!in_req) begin
            if (launch) begin
                in_req   <= 1'b1;
                in_we    <= launch_we;
                in_addr  <= launch_addr;
                in_wdata <= launch_wdata;
                wait_cnt <= '0;
            end
        end else if (in_ack || at_limit) begin
            in_req   <= 1'b0;
            wait_cnt <= '0;
        end else begin
            wait_cnt <= wait_cnt + 1'b1;
        end
    end
endmodule

// File: rtl/br64_regs.sv
`timescale 1ns/1ps
// Register side of the bridge: data staging, command check and launch,
// sticky error bits and interrupt enable.
// Assumes rd_done and tmo_hit are single-cycle events from the engine.
module br64_regs
    import br64_pkg::*;
#(
    parameter int          DW    = 32,
    parameter int unsigned BASE  = 32'h0007_0000,
    localparam int         IN_AW = DW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  wstrobe_t          wstb,
    input  logic [DW-1:0]     wdata,
    input  logic              busy,
    input  logic              rd_done,
    input  logic [2*DW-1:0]   rd_data,
    input  logic              tmo_hit,
    output logic [DW-1:0]     data_hi,
    output logic [DW-1:0]     data_lo,
    output logic              launch,
    output logic              launch_we,
    output logic [IN_AW-1:0]  launch_addr,
    output logic              err_tmo,
    output logic              err_clash,
    output logic              err_range,
    output logic              irq_en
);
    logic [IN_AW:0] addr_sum;
    logic           overflow;

    // inner address with base; the top bit flags an overflow
    assign addr_sum    = {1'b0, wdata[IN_AW-1:0]} + (IN_AW+1)'(BASE);
    assign overflow    = addr_sum[IN_AW];
    assign launch_addr = addr_sum[IN_AW-1:0];
    assign launch_we   = wdata[DW-1];
    assign launch      = wstb.cmd && !busy && !overflow;

    // data staging; a read completion takes priority over host writes
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            data_hi <= '0;
            data_lo <= '0;
        end else if (rd_done) begin
            data_hi <= rd_data[2*DW-1:DW];
            data_lo <= rd_data[DW-1:0];
        end else begin
            if (wstb.hi) data_hi <= wdata;
            if (wstb.lo) data_lo <= wdata;
        end
    end

    // sticky error capture, cleared by the reset register
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            err_tmo   <= 1'b0;
            err_clash <= 1'b0;
            err_range <= 1'b0;
        end else if (wstb.rst) begin
            err_tmo   <= 1'b0;
            err_clash <= 1'b0;
            err_range <= 1'b0;
        end else begin
            if (tmo_hit)                          err_tmo   <= 1'b1;
            if (wstb.cmd && busy)                 err_clash <= 1'b1;
            if (wstb.cmd && !busy && overflow)    err_range <= 1'b1;
        end
    end

    // interrupt enable register
    always_ff @(posedge clk) begin
        if (!rst_n)        irq_en <= 1'b0;
        else if (wstb.irq) irq_en <= wdata[0];
    end
endmodule

// File: rtl/bridge32to64.sv
`timescale 1ns/1ps
// 32-bit to 64-bit register bridge top: outer decode, register side,
// inner engine and the read-back multiplexer.
// Assumes one outer access per cycle and a combinational read path.
module bridge32to64
    import br64_pkg::*;
#(
    parameter int          OUT_AW  = 6,
    parameter int unsigned BASE    = 32'h0007_0000,
    parameter int          TIMEOUT = 16,
    localparam int         DW      = 32,
    localparam int         IN_AW   = DW - 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              bus_sel,
    input  logic              bus_wr,
    input  logic [OUT_AW-1:0] bus_addr,
    input  logic [DW-1:0]     bus_wdata,
    output logic [DW-1:0]     bus_rdata,
    output logic              in_req,
    output logic              in_we,
    output logic [IN_AW-1:0]  in_addr,
    output logic [2*DW-1:0]   in_wdata,
    input  logic              in_ack,
    input  logic [2*DW-1:0]   in_rdata,
    output logic              irq
);
    regsel_e          rsel;
    wstrobe_t         wstb;
    logic [DW-1:0]    data_hi, data_lo, sts_word;
    logic             launch, launch_we, rd_done, tmo_hit;
    logic [IN_AW-1:0] launch_addr;
    logic             err_tmo, err_clash, err_range, irq_en, err_any;

    br64_decode #(.OUT_AW(OUT_AW)) u_dec (
        .bus_sel (bus_sel),
        .bus_wr  (bus_wr),
        .bus_addr(bus_addr),
        .rsel    (rsel),
        .wstb    (wstb)
    );

    br64_regs #(.DW(DW), .BASE(BASE)) u_regs (
        .clk        (clk),
        .rst_n      (rst_n),
        .wstb       (wstb),
        .wdata      (bus_wdata),
        .busy       (in_req),
        .rd_done    (rd_done),
        .rd_data    (in_rdata),
        .tmo_hit    (tmo_hit),
        .data_hi    (data_hi),
        .data_lo    (data_lo),
        .launch     (launch),
        .launch_we  (launch_we),
        .launch_addr(launch_addr),
        .err_tmo    (err_tmo),
        .err_clash  (err_clash),
        .err_range  (err_range),
        .irq_en     (irq_en)
    );

    br64_xfer #(.IN_AW(IN_AW), .WIDE_W(2*DW), .TIMEOUT(TIMEOUT)) u_xfer (
        .clk         (clk),
        .rst_n       (rst_n),
        .launch      (launch),
        .launch_we   (launch_we),
        .launch_addr (launch_addr),
        .launch_wdata({data_hi, data_lo}),
        .abort       (wstb.rst),
        .in_req      (in_req),
        .in_we       (in_we),
        .in_addr     (in_addr),
        .in_wdata    (in_wdata),
        .in_ack      (in_ack),
        .rd_done     (rd_done),
        .tmo_hit     (tmo_hit)
    );

    assign err_any = err_tmo || err_clash || err_range;
    assign irq     = irq_en && err_any;

    // status word assembly
    always_comb begin
        sts_word            = '0;
        sts_word[STS_BUSY]  = in_req;
        sts_word[STS_TMO]   = err_tmo;
        sts_word[STS_CLASH] = err_clash;
        sts_word[STS_RANGE] = err_range;
        sts_word[STS_ANY]   = err_any;
    end

    // read-back multiplexer
    always_comb begin
        case (rsel)
            SEL_HI:  bus_rdata = data_hi;
            SEL_LO:  bus_rdata = data_lo;
            SEL_STS: bus_rdata = sts_word;
            SEL_IRQ: bus_rdata = {{(DW-1){1'b0}}, irq_en};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/br64_chk.sv
`timescale 1ns/1ps
// Protocol and status checker for the bridge, attached by bind.
// Assumes it sees the top-level ports and the assembled status word.
module br64_chk #(
    parameter int          OUT_AW = 6,
    parameter int          IN_AW  = 31,
    parameter int unsigned BASE   = 32'h0007_0000
) (
    input logic              clk,
    input logic              rst_n,
    input logic              bus_sel,
    input logic              bus_wr,
    input logic [OUT_AW-1:0] bus_addr,
    input logic [31:0]       bus_wdata,
    input logic              in_req,
    input logic              in_ack,
    input logic [IN_AW-1:0]  in_addr,
    input logic [31:0]       sts
);
    logic           cmd_wr, rst_wr;
    logic [IN_AW:0] chk_sum;

    assign cmd_wr  = bus_sel && bus_wr && (bus_addr == OUT_AW'(6'h08));
    assign rst_wr  = bus_sel && bus_wr && (bus_addr == OUT_AW'(6'h18));
    assign chk_sum = {1'b0, bus_wdata[IN_AW-1:0]} + (IN_AW+1)'(BASE);

    AST_ADDR_HELD: assert property (@(posedge clk) disable iff (!rst_n)
        in_req |=> $stable(in_addr)); // R3
    AST_ACK_RELEASE: assert property (@(posedge clk) disable iff (!rst_n)
        (in_req && in_ack && !rst_wr) |=> !in_req); // R4
    AST_CLASH_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && in_req) |=> sts[2]); // R7
    AST_RANGE_REJECT: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_wr && !in_req && chk_sum[IN_AW]) |=> (!in_req && sts[3])); // R8
    AST_ERR_STICKY: assert property (@(posedge clk) disable iff (!rst_n)
        (sts[31] && !rst_wr) |=> sts[31]); // R9
    AST_RESET_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        rst_wr |=> (!in_req && !sts[31])); // R9
endmodule

bind bridge32to64 br64_chk #(.OUT_AW(OUT_AW), .IN_AW(IN_AW), .BASE(BASE)) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .bus_sel  (bus_sel),
    .bus_wr   (bus_wr),
    .bus_addr (bus_addr),
    .bus_wdata(bus_wdata),
    .in_req   (in_req),
    .in_ack   (in_ack),
    .in_addr  (in_addr),
    .sts      (sts_word)
);

// File: tb/tb_bridge32to64.sv
`timescale 1ns/1ps
module tb_bridge32to64;
    localparam int          TMO   = 16;
    localparam logic [30:0] BASEV = 31'h0007_0000;
    localparam int          NVEC  = 5;
    // {is_write, addr[30:0], hi[31:0], lo[31:0], ack_delay[7:0]}
    localparam logic [103:0] VEC [NVEC] = '{
        {1'b1, 31'h0000_0010,   32'hDEAD_BEEF, 32'h0123_4567, 8'd0},
        {1'b0, 31'h0000_0020,   32'hA5A5_0001, 32'h5A5A_0002, 8'd3},
        {1'b1, 31'h7FF8_FFFF,   32'hFFFF_FFFF, 32'h0000_0000, 8'd15},
        {1'b0, 31'h0000_0000,   32'h0000_0000, 32'hFFFF_FFFF, 8'd7},
        {1'b0, 31'h0000_1234,   32'h8000_0000, 32'h0000_0001, 8'd15}
    };

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        bus_sel = 1'b0, bus_wr = 1'b0;
    logic [5:0]  bus_addr = '0;
    logic [31:0] bus_wdata = '0;
    logic [31:0] bus_rdata;
    logic        in_req, in_we, in_ack = 1'b0, irq;
    logic [30:0] in_addr;
    logic [63:0] in_wdata, in_rdata = '0;

    int n_chk = 0;
    int n_err = 0;
    bit done = 1'b0;

    always #4 clk = ~clk;

    bridge32to64 dut (
        .clk(clk), .rst_n(rst_n), .bus_sel(bus_sel), .bus_wr(bus_wr),
        .bus_addr(bus_addr), .bus_wdata(bus_wdata), .bus_rdata(bus_rdata),
        .in_req(in_req), .in_we(in_we), .in_addr(in_addr), .in_wdata(in_wdata),
        .in_ack(in_ack), .in_rdata(in_rdata), .irq(irq)
    );

    task automatic check(input string req, input logic [63:0] act, input logic [63:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_err++;
            $display("FAIL %s: actual %h expected %h", req, act, exp);
        end
    endtask

    task automatic wr(input logic [5:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_sel = 1'b1; bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_sel = 1'b0; bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [5:0] a, output logic [31:0] d);
        bus_sel = 1'b1; bus_wr = 1'b0; bus_addr = a;
        #1 d = bus_rdata;
        bus_sel = 1'b0;
    endtask

    task automatic expect_reg(input string req, input logic [5:0] a, input logic [31:0] exp);
        logic [31:0] v;
        rd(a, v);
        check(req, {32'h0, v}, {32'h0, exp});
    endtask

    task automatic ack_after(input int d, input logic [63:0] data);
        repeat (d) @(negedge clk);
        in_ack = 1'b1; in_rdata = data;
        @(negedge clk);
        in_ack = 1'b0;
    endtask

    initial begin
        #(8 * 200000);
        if (!done) begin
            n_err++; n_chk++;
            $display("FAIL watchdog: actual hung expected finish");
            $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
            $finish;
        end
    end

    initial begin
        logic [31:0] v;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        // R1 reset state
        check("R1 in_req", {63'h0, in_req}, 64'h0);
        check("R1 irq", {63'h0, irq}, 64'h0);
        expect_reg("R1 hi", 6'h00, 32'h0);
        expect_reg("R1 lo", 6'h04, 32'h0);
        expect_reg("R1 status", 6'h1C, 32'h0);
        expect_reg("R1 irq reg", 6'h20, 32'h0);

        // table walk: R2 R3 R4 R5 R6 (delay 15 = last allowed cycle)
        for (int i = 0; i < NVEC; i++) begin
            logic        isw;
            logic [30:0] a;
            logic [31:0] hi, lo;
            int          dly;
            logic [31:0] prev_hi, prev_lo;
            {isw, a, hi, lo} = VEC[i][103:8];
            dly = int'(VEC[i][7:0]);
            if (isw) begin
                wr(6'h00, hi); wr(6'h04, lo);
                expect_reg("R2 hi readback", 6'h00, hi);
                expect_reg("R2 lo readback", 6'h04, lo);
            end
            rd(6'h00, prev_hi); rd(6'h04, prev_lo);
            wr(6'h08, {isw, a});
            check("R3 in_req", {63'h0, in_req}, 64'h1);
            check("R3 in_we", {63'h0, in_we}, {63'h0, isw});
            check("R3 in_addr", {33'h0, in_addr}, {33'h0, a + BASEV});
            if (isw) check("R3 in_wdata", in_wdata, {hi, lo});
            expect_reg("R5 busy", 6'h1C, 32'h1);
            ack_after(dly, {hi, lo});
            check("R4 req drop", {63'h0, in_req}, 64'h0);
            expect_reg("R6 no timeout", 6'h1C, 32'h0);
            if (isw) begin
                expect_reg("R2 hi kept", 6'h00, prev_hi);
                expect_reg("R2 lo kept", 6'h04, prev_lo);
            end else begin
                expect_reg("R4 hi captured", 6'h00, hi);
                expect_reg("R4 lo captured", 6'h04, lo);
            end
        end

        // R8 range error with interrupt disabled (R10)
        wr(6'h08, {1'b0, 31'h7FF9_0000});
        check("R8 no launch", {63'h0, in_req}, 64'h0);
        expect_reg("R8 status", 6'h1C, 32'h8000_0008);
        check("R10 irq off", {63'h0, irq}, 64'h0);
        wr(6'h20, 32'h1);
        expect_reg("R10 enable readback", 6'h20, 32'h1);
        check("R10 irq on", {63'h0, irq}, 64'h1);
        wr(6'h18, 32'h0);
        expect_reg("R9 cleared", 6'h1C, 32'h0);
        check("R10 irq clears", {63'h0, irq}, 64'h0);
        wr(6'h08, {1'b1, 31'h7FFF_FFFF});
        check("R8 write no launch", {63'h0, in_req}, 64'h0);
        expect_reg("R8 write status", 6'h1C, 32'h8000_0008);
        wr(6'h18, 32'h0);

        // R6 timeout
        wr(6'h00, 32'h1111_2222); wr(6'h04, 32'h3333_4444);
        wr(6'h08, {1'b0, 31'h40});
        repeat (TMO - 1) @(negedge clk);
        check("R6 still waiting", {63'h0, in_req}, 64'h1);
        @(negedge clk);
        check("R6 dropped", {63'h0, in_req}, 64'h0);
        expect_reg("R6 status", 6'h1C, 32'h8000_0002);
        check("R10 irq timeout", {63'h0, irq}, 64'h1);
        expect_reg("R6 hi kept", 6'h00, 32'h1111_2222);
        @(negedge clk);
        expect_reg("R9 sticky", 6'h1C, 32'h8000_0002);
        wr(6'h18, 32'h0);
        expect_reg("R9 cleared tmo", 6'h1C, 32'h0);

        // R7 command while busy
        wr(6'h08, {1'b1, 31'h100});
        wr(6'h08, {1'b1, 31'h200});
        check("R7 addr kept", {33'h0, in_addr}, {33'h0, 31'h100 + BASEV});
        expect_reg("R7 status busy", 6'h1C, 32'h8000_0005);
        ack_after(0, 64'h0);
        expect_reg("R7 status after", 6'h1C, 32'h8000_0004);
        wr(6'h18, 32'h0);

        // R9 abort by reset register and late acknowledge ignored
        wr(6'h08, {1'b0, 31'h300});
        check("R9 launched", {63'h0, in_req}, 64'h1);
        wr(6'h18, 32'h0);
        check("R9 aborted", {63'h0, in_req}, 64'h0);
        ack_after(0, 64'hCAFE_F00D_BAAD_D00D);
        expect_reg("R9 late ack hi", 6'h00, 32'h1111_2222);
        expect_reg("R9 late ack lo", 6'h04, 32'h3333_4444);
        expect_reg("R9 status", 6'h1C, 32'h0);

        // R11 unmapped offsets
        wr(6'h0C, 32'hFFFF_FFFF);
        wr(6'h10, 32'hFFFF_FFFF);
        expect_reg("R11 hi unchanged", 6'h00, 32'h1111_2222);
        expect_reg("R11 lo unchanged", 6'h04, 32'h3333_4444);
        expect_reg("R11 irq unchanged", 6'h20, 32'h1);
        expect_reg("R11 unmapped read", 6'h0C, 32'h0);
        expect_reg("R11 cmd read", 6'h08, 32'h0);
        expect_reg("R11 rst read", 6'h18, 32'h0);
        check("R11 no launch", {63'h0, in_req}, 64'h0);

        done = 1'b1;
        $display("%0d/%0d checks passed", n_chk - n_err, n_chk);
        $finish;
    end
endmodule